// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address by reading two linked tables held in its own word-addressed table memory. The virtual address is cut into a first index, a second index and a byte offset. The first index is added to a root pointer register to pick a first-level entry. That entry holds the base of a second-level table, and the second index is added to this base to pick the final entry. The final entry holds a frame number, which is placed above the unchanged offset to form the physical address.

A client offers one address at a time on a valid/ready handshake. It gets back a single-cycle response that carries either the physical address or a fault flag, together with the level whose entry was marked invalid. A host port fills the table memory and loads the root pointer. The walk takes one synchronous memory read per level, so each translation costs two table reads before any data access can start.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: The 20-bit virtual address is split as first index = bits 19:15, second index = bits 14:10 and offset = bits 9:0.
- R3: A table entry is 9 bits wide. Bit 8 is the valid flag and bits 7:0 hold a table base. The first-level entry is read at word (root + first index) modulo 256.
- R4: The second-level entry is read at word (first-level base + second index) modulo 256. Its valid flag is bit 8 and its frame number is bits 5:0.
- R5: On success, `rsp_paddr` = {frame number, offset}, 16 bits wide, and `rsp_fault` is 0.
- R6: If the first-level entry has its valid flag clear, the response has `rsp_fault`=1, `rsp_fault_lvl`=0 and `rsp_paddr`=0. It arrives 2 cycles after the accepting clock edge.
- R7: If the second-level entry has its valid flag clear, the response has `rsp_fault`=1 and `rsp_fault_lvl`=1. It arrives 3 cycles after the accepting clock edge.
- R8: A successful response arrives 3 cycles after the accepting edge. `rsp_valid` is high for exactly one cycle, and `req_ready` returns to 1 in the following cycle.
- R9: `req_ready` is 0 from the cycle after acceptance through the response cycle. `req_valid` is ignored during that time, so no extra response appears.
- R10: When `host_we`=1 and `host_sel_root`=1, the root pointer is loaded from `host_wdata[7:0]`. When `host_we`=1 and `host_sel_root`=0, table word `host_addr` is written. When `host_we`=0, the root pointer and the table are left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 20 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 16 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Translation failed |
| rsp_fault_lvl | output | 1 | Level whose entry was invalid (0 = first, 1 = second) |
| host_we | input | 1 | Host write strobe |
| host_sel_root | input | 1 | Host write targets the root pointer instead of the table |
| host_addr | input | 8 | Table word address for host writes |
| host_wdata | input | 9 | Host write data (entry, or root in bits 7:0) |

## Verification
The assertions assume that every table word a walk reads has been written beforehand, so that the valid flag is never unknown. They also assume that the host does not write the table or the root while a walk is in progress. The stimulus first clears all 256 words to invalid. It then issues host writes only while the walker is idle, and it checks `req_ready` before every request it offers. Requests offered during a busy walk are deliberate, and they are withdrawn before the walker returns to idle.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_L1   = 2'd1,
    WS_L2   = 2'd2,
    WS_DONE = 2'd3
  } walk_state_e;
endpackage

// File: rtl/pgwalk_rst_sync.sv
module pgwalk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/pgwalk_root.sv
module pgwalk_root #(
  parameter int TAB_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [TAB_AW-1:0] wr_val,
  output logic [TAB_AW-1:0] root
);
  logic [TAB_AW-1:0] root_q, root_d;

  always_comb begin
    root_d = root_q;
    if (wr_en) root_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) root_q <= '0;
    else        root_q <= root_d;
  end

  assign root = root_q;

  AST_ROOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(root_q)); // R10
endmodule

// File: rtl/pgwalk_ram.sv
module pgwalk_ram #(
  parameter int AW = 8,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/pgwalk_fsm.sv
module pgwalk_fsm
  import pgwalk_pkg::*;
#(
  parameter int P1_W    = 5,
  parameter int P2_W    = 5,
  parameter int OFF_W   = 10,
  parameter int FRAME_W = 6,
  parameter int TAB_AW  = 8,
  localparam int VA_W   = P1_W + P2_W + OFF_W,
  localparam int PA_W   = FRAME_W + OFF_W,
  localparam int ENT_W  = 1 + TAB_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [TAB_AW-1:0] root,
  output logic              ram_re,
  output logic [TAB_AW-1:0] ram_raddr,
  input  logic [ENT_W-1:0]  ram_rdata,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_fault,
  output logic              rsp_fault_lvl
);
  walk_state_e st_q, st_d;

  logic [P2_W-1:0]  p2_q, p2_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [PA_W-1:0]  pa_q, pa_d;
  logic             flt_q, flt_d;
  logic             lvl_q, lvl_d;

  logic             accept;
  logic             ent_valid;
  logic [P1_W-1:0]  req_p1;
  logic [TAB_AW-1:0] l1_addr, l2_addr;
  logic             rsp_load;

  assign req_ready = (st_q == WS_IDLE);
  assign accept    = req_valid && req_ready;
  assign ent_valid = ram_rdata[ENT_W-1];
  assign req_p1    = req_vaddr[VA_W-1 -: P1_W];

  assign l1_addr = root + TAB_AW'(req_p1);
  assign l2_addr = ram_rdata[TAB_AW-1:0] + TAB_AW'(p2_q);

  always_comb begin
    ram_re    = 1'b0;
    ram_raddr = l1_addr;
    if (accept) begin
      ram_re    = 1'b1;
      ram_raddr = l1_addr;
    end else if (st_q == WS_L1 && ent_valid) begin
      ram_re    = 1'b1;
      ram_raddr = l2_addr;
    end
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      WS_IDLE: if (accept) st_d = WS_L1;
      WS_L1:   st_d = ent_valid ? WS_L2 : WS_DONE;
      WS_L2:   st_d = WS_DONE;
      WS_DONE: st_d = WS_IDLE;
      default: st_d = WS_IDLE;
    endcase
  end

  always_comb begin
    p2_d  = p2_q;
    off_d = off_q;
    if (accept) begin
      p2_d  = req_vaddr[OFF_W +: P2_W];
      off_d = req_vaddr[OFF_W-1:0];
    end
  end

  assign rsp_load = (st_q == WS_L1 && !ent_valid) || (st_q == WS_L2);

  always_comb begin
    pa_d  = pa_q;
    flt_d = flt_q;
    lvl_d = lvl_q;
    if (rsp_load) begin
      if (!ent_valid) begin
        pa_d  = '0;
        flt_d = 1'b1;
        lvl_d = (st_q == WS_L2);
      end else begin
        pa_d  = {ram_rdata[FRAME_W-1:0], off_q};
        flt_d = 1'b0;
        lvl_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WS_IDLE;
      p2_q  <= '0;
      off_q <= '0;
      pa_q  <= '0;
      flt_q <= 1'b0;
      lvl_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      p2_q  <= p2_d;
      off_q <= off_d;
      pa_q  <= pa_d;
      flt_q <= flt_d;
      lvl_q <= lvl_d;
    end
  end

  assign rsp_valid     = (st_q == WS_DONE);
  assign rsp_paddr     = pa_q;
  assign rsp_fault     = rsp_valid && flt_q;
  assign rsp_fault_lvl = rsp_valid && lvl_q;

  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R9

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready)); // R8

  AST_L1_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WS_L1 && !ent_valid) |=>
      (rsp_valid && rsp_fault && !rsp_fault_lvl && rsp_paddr == '0)); // R6

  AST_L2_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WS_L2 && !ent_valid) |=> (rsp_valid && rsp_fault && rsp_fault_lvl)); // R7

  AST_L2_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WS_L2 && ent_valid) |=>
      (rsp_valid && !rsp_fault &&
       rsp_paddr[PA_W-1:OFF_W] == $past(ram_rdata[FRAME_W-1:0]))); // R5
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
  parameter int P1_W    = 5,
  parameter int P2_W    = 5,
  parameter int OFF_W   = 10,
  parameter int FRAME_W = 6,
  parameter int TAB_AW  = 8,
  localparam int VA_W   = P1_W + P2_W + OFF_W,
  localparam int PA_W   = FRAME_W + OFF_W,
  localparam int ENT_W  = 1 + TAB_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_fault,
  output logic              rsp_fault_lvl,
  input  logic              host_we,
  input  logic              host_sel_root,
  input  logic [TAB_AW-1:0] host_addr,
  input  logic [ENT_W-1:0]  host_wdata
);
  logic              rst_n_sync;
  logic [TAB_AW-1:0] root;
  logic              ram_re;
  logic [TAB_AW-1:0] ram_raddr;
  logic [ENT_W-1:0]  ram_rdata;
  logic              root_we, tab_we;

  assign root_we = host_we && host_sel_root;
  assign tab_we  = host_we && !host_sel_root;

  pgwalk_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  pgwalk_root #(.TAB_AW(TAB_AW)) u_root (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .wr_en  (root_we),
    .wr_val (host_wdata[TAB_AW-1:0]),
    .root   (root)
  );

  pgwalk_ram #(.AW(TAB_AW), .DW(ENT_W)) u_ram (
    .clk   (clk),
    .we    (tab_we),
    .waddr (host_addr),
    .wdata (host_wdata),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  pgwalk_fsm #(
    .P1_W(P1_W), .P2_W(P2_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W), .TAB_AW(TAB_AW)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n_sync),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .root          (root),
    .ram_re        (ram_re),
    .ram_raddr     (ram_raddr),
    .ram_rdata     (ram_rdata),
    .rsp_valid     (rsp_valid),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault),
    .rsp_fault_lvl (rsp_fault_lvl)
  );
endmodule

// File: tb/pgwalk_top_tb.sv
module pgwalk_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [19:0] req_vaddr;
  logic        rsp_valid;
  logic [15:0] rsp_paddr;
  logic        rsp_fault;
  logic        rsp_fault_lvl;
  logic        host_we;
  logic        host_sel_root;
  logic [7:0]  host_addr;
  logic [8:0]  host_wdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pgwalk_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .rsp_fault_lvl(rsp_fault_lvl),
    .host_we(host_we), .host_sel_root(host_sel_root),
    .host_addr(host_addr), .host_wdata(host_wdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] mk_va(input logic [4:0] p1, input logic [4:0] p2,
                                        input logic [9:0] off);
    return {p1, p2, off};
  endfunction

  task automatic host_write(input logic sel_root, input logic [7:0] a, input logic [8:0] d);
    @(negedge clk);
    host_we = 1'b1; host_sel_root = sel_root; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0; host_sel_root = 1'b0;
  endtask

  task automatic walk(input string tag, input logic [19:0] va, input logic exp_flt,
                      input logic exp_lvl, input logic [15:0] exp_pa, input int exp_lat);
    int cyc;
    @(negedge clk);
    check({tag, " ready before request"}, req_ready, 1);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 ready low while busy", req_ready, 0);
    cyc = 1;
    while (!rsp_valid && cyc < 8) begin
      @(negedge clk);
      cyc++;
    end
    check({tag, " latency"}, cyc, exp_lat);
    check({tag, " fault"}, rsp_fault, exp_flt);
    if (exp_flt) check({tag, " fault level"}, rsp_fault_lvl, exp_lvl);
    check({tag, " paddr"}, rsp_paddr, exp_pa);
    @(negedge clk);
    check("R8 response single cycle", rsp_valid, 0);
    check("R8 ready back", req_ready, 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0;
    host_we = 1'b0; host_sel_root = 1'b0; host_addr = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ready after reset", req_ready, 1);
    check("R1 no response after reset", rsp_valid, 0);
  endtask

  task automatic t_clear_table();
    for (int i = 0; i < 256; i++) host_write(1'b0, 8'(i), 9'h000);
  endtask

  task automatic t_basic();
    host_write(1'b1, 8'h00, 9'h010);          // root = 0x10
    host_write(1'b0, 8'h13, 9'h140);          // L1[0x10+3] -> base 0x40
    host_write(1'b0, 8'h47, 9'h12A);          // L2[0x40+7] -> frame 0x2A
    walk("R2/R3/R4/R5", mk_va(5'd3, 5'd7, 10'h155), 1'b0, 1'b0, 16'hA955, 3);
    walk("R5 offset zero", mk_va(5'd3, 5'd7, 10'h000), 1'b0, 1'b0, 16'hA800, 3);
    walk("R5 offset max", mk_va(5'd3, 5'd7, 10'h3FF), 1'b0, 1'b0, 16'hABFF, 3);
  endtask

  task automatic t_faults();
    walk("R6 first-level invalid", mk_va(5'd4, 5'd7, 10'h001), 1'b1, 1'b0, 16'h0000, 2);
    walk("R7 second-level invalid", mk_va(5'd3, 5'd8, 10'h001), 1'b1, 1'b1, 16'h0000, 3);
  endtask

  task automatic t_wrap();
    host_write(1'b1, 8'h00, 9'h0F0);          // root = 0xF0
    host_write(1'b0, 8'h0F, 9'h1FC);          // 0xF0+0x1F wraps to 0x0F, base 0xFC
    host_write(1'b0, 8'h01, 9'h13F);          // 0xFC+5 wraps to 0x01, frame 0x3F
    walk("R3/R4 wrap", mk_va(5'd31, 5'd5, 10'h3FF), 1'b0, 1'b0, 16'hFFFF, 3);
    walk("R10 new root used", mk_va(5'd3, 5'd7, 10'h155), 1'b1, 1'b0, 16'h0000, 2);
  endtask

  task automatic t_host_idle();
    @(negedge clk);
    host_we = 1'b0; host_sel_root = 1'b1; host_addr = 8'h13; host_wdata = 9'h010;
    @(negedge clk);
    host_sel_root = 1'b0;
    walk("R10 no write without strobe", mk_va(5'd31, 5'd5, 10'h000), 1'b0, 1'b0, 16'hFC00, 3);
    host_write(1'b1, 8'h00, 9'h010);
    walk("R10 root restored", mk_va(5'd3, 5'd7, 10'h155), 1'b0, 1'b0, 16'hA955, 3);
  endtask

  task automatic t_busy_ignore();
    int extra = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = mk_va(5'd3, 5'd7, 10'h0AA);
    @(negedge clk);
    req_vaddr = mk_va(5'd4, 5'd0, 10'h111);   // held while busy
    check("R9 ready low with request held", req_ready, 0);
    @(negedge clk);
    check("R9 still busy", req_ready, 0);
    req_valid = 1'b0;
    @(negedge clk);
    check("R9 response is first request", rsp_valid, 1);
    check("R9 response paddr", rsp_paddr, 16'hA8AA);
    check("R9 response fault", rsp_fault, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (rsp_valid) extra++;
    end
    check("R9 no extra response", extra, 0);
  endtask

  initial begin
    t_reset();
    t_clear_table();
    t_basic();
    t_faults();
    t_wrap();
    t_host_idle();
    t_busy_ignore();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule